// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block performs the register side of taking a trap in a MIPS-style system-control coprocessor. A pipeline raises a single-cycle request with a cause code, a flag that says whether the faulting instruction sat in a branch-delay slot, its program counter and, for a translation miss, the virtual address that missed. On that clock edge the block updates its status, cause, exception-PC, bad-address, context and entry-high registers. On the following cycle it presents the fetch address of the handler as a one-cycle redirect.

The handler address comes from a two-level priority scheme. Error level (status ERL) is checked first and then exception level (status EXL). A per-level bit selects between a cached kernel base and a boot-ROM base. When EXL is already set, the general offset is forced. A separate combinational output tells the pipeline whether a pending interrupt line, given as a status mask, may be taken under the current status enables. A simple write port loads the coprocessor registers so that a test can set up any status.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, redirectPc is 0xBFC00000, statusOut is 0x70400004, configOut is 0x440, pridOut is 0x00002E20, and redirectValid and levelErr are 0.
- R2: A reqValid pulse updates every affected register on the clock edge that samples it. redirectValid is then 1 for exactly the next cycle, and 0 whenever the previous edge saw no request.
- R3: With ERL (status bit 2) clear and EXL clear, the field reqCode[6:2] selects the offset: 2 or 3 gives 0x000, 0 gives 0x200, and any other value gives 0x180.
- R4: With ERL set, reqCode[17:15] selects the action. A value of 0 or 1 redirects to 0xBFC00000 and leaves status, exception-PC and cause bit 31 unchanged. A value of 2 gives offset 0x080 and 3 gives offset 0x100. Any value from 4 to 7 gives offset 0x000 and sets levelErr, which stays set until reset.
- R5: The base is 0x80000000 when the selecting bit is 0 and 0xBFC00200 when it is 1. The selecting bit is status bit 22 when ERL is clear and status bit 23 when ERL is set.
- R6: When EXL (status bit 1) is clear on entry, and the request is not a level-two reset, EXL becomes 1. The exception-PC receives the fault PC minus 4 if reqBranchDelay is set, or the fault PC if it is clear, and cause bit 31 takes the value of reqBranchDelay.
- R7: When EXL is already set on entry, the exception-PC and cause bit 31 keep their values and the offset is forced to 0x180 at either level.
- R8: On every request, causeOut[15:0] receives reqCode[15:0] and causeOut[30:16] is cleared.
- R9: With reqTlbMiss set, several registers change and the fault PC is reqPc minus 4 instead of reqPc. The bad-address register receives reqBadAddr. The context register keeps its bits under 0xFF80000F and takes (reqBadAddr >> 9) & 0x007FFFF0. Entry-high receives reqBadAddr & 0xFFFFE000 joined with its own low 13 bits.
- R10: intTake is 1 exactly when (statusOut & intMask) is nonzero, status bit 0 is 1, status bit 16 is 1, EXL is 0 and ERL is 0. Bit 10 is the interrupt-controller line and bit 11 is the DMA-controller line.
- R11: With wrEn high and no request, wrSel 0 to 5 loads wrData into status, cause, exception-PC, bad-address, context or entry-high respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Single-cycle exception request |
| reqCode | input | 18 | Cause code of the request |
| reqBranchDelay | input | 1 | Faulting instruction is in a delay slot |
| reqTlbMiss | input | 1 | Request is a translation miss |
| reqPc | input | 32 | PC of the faulting instruction |
| reqBadAddr | input | 32 | Virtual address that missed |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for writes |
| wrData | input | 32 | Write data |
| intMask | input | 32 | Status mask of a pending interrupt line |
| intTake | output | 1 | Interrupt may be taken |
| redirectValid | output | 1 | One-cycle redirect flag |
| redirectPc | output | 32 | Handler fetch address |
| statusOut | output | 32 | Status register |
| causeOut | output | 32 | Cause register |
| epcOut | output | 32 | Exception-PC register |
| badVaddrOut | output | 32 | Bad virtual address register |
| contextOut | output | 32 | Context register |
| entryHiOut | output | 32 | Entry-high register |
| configOut | output | 32 | Configuration value |
| pridOut | output | 32 | Processor identification value |
| levelErr | output | 1 | Sticky unknown level-two code flag |

## Verification
The assertions assume that requests are isolated pulses and that no write strobe coincides with a request. Under that assumption a register that should hold can be compared with its value one edge earlier. The stimulus keeps to this by raising reqValid for one cycle at a time, with register set-up writes in separate earlier cycles. Between requests the bench rewrites status, cause, exception-PC, context and entry-high to known seeds, so every sweep point starts from a state that the bench model knows.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 18;
  localparam int SEL_W  = 3;
  localparam int OFF_W  = 10;
  localparam int CAUSE_KEEP = 16;

  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_EIE = 16;
  localparam int ST_BEV = 22;
  localparam int ST_DEV = 23;

  localparam logic [XLEN-1:0] CTX_KEEP  = 32'hFF80000F;
  localparam logic [XLEN-1:0] CTX_FIELD = 32'h007FFFF0;
  localparam logic [XLEN-1:0] HI_VPN    = 32'hFFFFE000;

  localparam logic [OFF_W-1:0] OFF_REFILL  = 10'h000;
  localparam logic [OFF_W-1:0] OFF_PERF    = 10'h080;
  localparam logic [OFF_W-1:0] OFF_DEBUG   = 10'h100;
  localparam logic [OFF_W-1:0] OFF_GENERAL = 10'h180;
  localparam logic [OFF_W-1:0] OFF_INTR    = 10'h200;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_EPC     = 3'd2,
    SEL_BADVA   = 3'd3,
    SEL_CONTEXT = 3'd4,
    SEL_ENTRYHI = 3'd5
  } regSelT;

  typedef struct packed {
    logic take;
    logic resetVec;
    logic saveEpc;
    logic tlbUpdate;
    logic badLevel;
  } trapStrobeT;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC  = 32'hBFC00000,
  parameter logic [XLEN-1:0] KSEG_BASE = 32'h80000000,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC00200
) (
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              reqTlbMiss,
  input  logic [XLEN-1:0]   statusQ,
  input  logic [XLEN-1:0]   intMask,
  output trapStrobeT        strobe,
  output logic [XLEN-1:0]   vectorPc,
  output logic              intTake
);
  logic             errLevel;
  logic             excLevel;
  logic             useBoot;
  logic [4:0]       excField;
  logic [2:0]       lvlField;
  logic [OFF_W-1:0] lvlOneOff;
  logic [OFF_W-1:0] lvlTwoOff;
  logic [OFF_W-1:0] offset;
  logic             lvlTwoReset;
  logic             lvlTwoUnknown;
  logic [XLEN-1:0]  baseAddr;

  assign errLevel = statusQ[ST_ERL];
  assign excLevel = statusQ[ST_EXL];
  assign excField = reqCode[6:2];
  assign lvlField = reqCode[17:15];

  always_comb begin
    if (excField == 5'd2 || excField == 5'd3) lvlOneOff = OFF_REFILL;
    else if (excField == 5'd0)                lvlOneOff = OFF_INTR;
    else                                      lvlOneOff = OFF_GENERAL;
  end

  always_comb begin
    lvlTwoReset   = 1'b0;
    lvlTwoUnknown = 1'b0;
    lvlTwoOff     = OFF_REFILL;
    case (lvlField)
      3'd0, 3'd1: lvlTwoReset = 1'b1;
      3'd2:       lvlTwoOff   = OFF_PERF;
      3'd3:       lvlTwoOff   = OFF_DEBUG;
      default:    lvlTwoUnknown = 1'b1;
    endcase
  end

  always_comb begin
    offset  = errLevel ? lvlTwoOff : lvlOneOff;
    if (excLevel) offset = OFF_GENERAL;
    useBoot = errLevel ? statusQ[ST_DEV] : statusQ[ST_BEV];
    baseAddr = useBoot ? BOOT_BASE : KSEG_BASE;
  end

  always_comb begin
    if (errLevel && lvlTwoReset) vectorPc = RESET_PC;
    else vectorPc = baseAddr + {{(XLEN-OFF_W){1'b0}}, offset};
  end

  always_comb begin
    strobe.take      = reqValid;
    strobe.resetVec  = reqValid && errLevel && lvlTwoReset;
    strobe.saveEpc   = reqValid && !excLevel && !(errLevel && lvlTwoReset);
    strobe.tlbUpdate = reqValid && reqTlbMiss;
    strobe.badLevel  = reqValid && errLevel && lvlTwoUnknown;
  end

  assign intTake = (|(statusQ & intMask)) && statusQ[ST_IE] && statusQ[ST_EIE]
                   && !excLevel && !errLevel;
endmodule

// File: rtl/trap_entry_regs.sv
module trap_entry_regs
  import trap_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC    = 32'hBFC00000,
  parameter logic [XLEN-1:0] STATUS_INIT = 32'h70400004
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trapStrobeT            strobe,
  input  logic [XLEN-1:0]       vectorPc,
  input  logic [CAUSE_KEEP-1:0] causeBits,
  input  logic                  reqBranchDelay,
  input  logic [XLEN-1:0]       reqPc,
  input  logic [XLEN-1:0]       reqBadAddr,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      wrSel,
  input  logic [XLEN-1:0]       wrData,
  output logic [XLEN-1:0]       statusQ,
  output logic [XLEN-1:0]       causeQ,
  output logic [XLEN-1:0]       epcQ,
  output logic [XLEN-1:0]       badVaQ,
  output logic [XLEN-1:0]       contextQ,
  output logic [XLEN-1:0]       entryHiQ,
  output logic [XLEN-1:0]       redirectPcQ,
  output logic                  redirectValidQ,
  output logic                  levelErrQ
);
  logic [XLEN-1:0] faultPc;
  logic [XLEN-1:0] epcNext;
  logic            wrLive;

  assign faultPc = strobe.tlbUpdate ? reqPc - XLEN'(4) : reqPc;
  assign epcNext = reqBranchDelay ? faultPc - XLEN'(4) : faultPc;
  assign wrLive  = wrEn && !strobe.take;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValidQ <= 1'b0;
      redirectPcQ    <= RESET_PC;
      levelErrQ      <= 1'b0;
    end else begin
      redirectValidQ <= strobe.take;
      if (strobe.take) redirectPcQ <= vectorPc;
      if (strobe.badLevel) levelErrQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STATUS_INIT;
    end else if (strobe.saveEpc) begin
      statusQ[ST_EXL] <= 1'b1;
    end else if (wrLive && regSelT'(wrSel) == SEL_STATUS) begin
      statusQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
    end else if (strobe.take) begin
      causeQ <= {strobe.saveEpc ? reqBranchDelay : causeQ[XLEN-1],
                 {(XLEN-1-CAUSE_KEEP){1'b0}}, causeBits};
    end else if (wrLive && regSelT'(wrSel) == SEL_CAUSE) begin
      causeQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ <= '0;
    end else if (strobe.saveEpc) begin
      epcQ <= epcNext;
    end else if (wrLive && regSelT'(wrSel) == SEL_EPC) begin
      epcQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badVaQ   <= '0;
      contextQ <= '0;
      entryHiQ <= '0;
    end else if (strobe.tlbUpdate) begin
      badVaQ   <= reqBadAddr;
      contextQ <= (contextQ & CTX_KEEP) | ((reqBadAddr >> 9) & CTX_FIELD);
      entryHiQ <= (reqBadAddr & HI_VPN) | (entryHiQ & ~HI_VPN);
    end else if (wrLive) begin
      case (regSelT'(wrSel))
        SEL_BADVA:   badVaQ   <= wrData;
        SEL_CONTEXT: contextQ <= wrData;
        SEL_ENTRYHI: entryHiQ <= wrData;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC    = 32'hBFC00000,
  parameter logic [XLEN-1:0] STATUS_INIT = 32'h70400004,
  parameter logic [XLEN-1:0] CONFIG_VAL  = 32'h00000440,
  parameter logic [XLEN-1:0] PRID_VAL    = 32'h00002E20,
  parameter logic [XLEN-1:0] KSEG_BASE   = 32'h80000000,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC00200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              reqBranchDelay,
  input  logic              reqTlbMiss,
  input  logic [XLEN-1:0]   reqPc,
  input  logic [XLEN-1:0]   reqBadAddr,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [XLEN-1:0]   wrData,
  input  logic [XLEN-1:0]   intMask,
  output logic              intTake,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc,
  output logic [XLEN-1:0]   statusOut,
  output logic [XLEN-1:0]   causeOut,
  output logic [XLEN-1:0]   epcOut,
  output logic [XLEN-1:0]   badVaddrOut,
  output logic [XLEN-1:0]   contextOut,
  output logic [XLEN-1:0]   entryHiOut,
  output logic [XLEN-1:0]   configOut,
  output logic [XLEN-1:0]   pridOut,
  output logic              levelErr
);
  trapStrobeT      strobe;
  logic [XLEN-1:0] vectorPc;

  trap_entry_ctrl #(
    .RESET_PC(RESET_PC), .KSEG_BASE(KSEG_BASE), .BOOT_BASE(BOOT_BASE)
  ) uCtrl (
    .reqValid(reqValid), .reqCode(reqCode), .reqTlbMiss(reqTlbMiss),
    .statusQ(statusOut), .intMask(intMask), .strobe(strobe),
    .vectorPc(vectorPc), .intTake(intTake)
  );

  trap_entry_regs #(
    .RESET_PC(RESET_PC), .STATUS_INIT(STATUS_INIT)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vectorPc(vectorPc),
    .causeBits(reqCode[CAUSE_KEEP-1:0]), .reqBranchDelay(reqBranchDelay),
    .reqPc(reqPc), .reqBadAddr(reqBadAddr), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .statusQ(statusOut), .causeQ(causeOut), .epcQ(epcOut),
    .badVaQ(badVaddrOut), .contextQ(contextOut), .entryHiQ(entryHiOut),
    .redirectPcQ(redirectPc), .redirectValidQ(redirectValid),
    .levelErrQ(levelErr)
  );

  assign configOut = CONFIG_VAL;
  assign pridOut   = PRID_VAL;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'hBFC00000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [CODE_W-1:0] reqCode,
  input logic              wrEn,
  input logic [XLEN-1:0]   intMask,
  input logic              intTake,
  input logic              redirectValid,
  input logic [XLEN-1:0]   redirectPc,
  input logic [XLEN-1:0]   statusOut,
  input logic [XLEN-1:0]   causeOut,
  input logic [XLEN-1:0]   epcOut,
  input logic              levelErr
);
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> redirectValid); // R2
  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !redirectValid); // R2
  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> redirectPc[6:0] == 7'd0); // R5
  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && statusOut[ST_ERL] && reqCode[17:15] <= 3'd1
      |=> redirectPc == RESET_PC && $stable(statusOut)); // R4
  AST_EXL_SET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !statusOut[ST_EXL] && !(statusOut[ST_ERL] && reqCode[17:15] <= 3'd1)
      |=> statusOut[ST_EXL]); // R6
  AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !wrEn && statusOut[ST_EXL] |=> $stable(epcOut)); // R7
  AST_CAUSE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> causeOut[15:0] == $past(reqCode[15:0])); // R8
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    intTake |-> statusOut[ST_IE] && statusOut[ST_EIE] && !statusOut[ST_EXL]
                && !statusOut[ST_ERL] && (statusOut & intMask) != '0); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    levelErr |=> levelErr); // R4
endmodule

bind trap_entry_unit trap_entry_chk #(.RESET_PC(RESET_PC)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
  .wrEn(wrEn), .intMask(intMask), .intTake(intTake),
  .redirectValid(redirectValid), .redirectPc(redirectPc),
  .statusOut(statusOut), .causeOut(causeOut), .epcOut(epcOut),
  .levelErr(levelErr)
);

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [17:0] reqCode = '0;
  logic        reqBranchDelay = 1'b0;
  logic        reqTlbMiss = 1'b0;
  logic [31:0] reqPc = '0;
  logic [31:0] reqBadAddr = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] intMask = '0;
  logic        intTake, redirectValid, levelErr;
  logic [31:0] redirectPc, statusOut, causeOut, epcOut, badVaddrOut;
  logic [31:0] contextOut, entryHiOut, configOut, pridOut;

  int checkCount = 0;
  int failCount = 0;
  logic [31:0] mStatus, mCause, mEpc, mBad, mCtx, mHi;
  logic        mErr = 1'b0;

  always #2.5 clk = ~clk;

  trap_entry_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .reqBranchDelay(reqBranchDelay), .reqTlbMiss(reqTlbMiss), .reqPc(reqPc),
    .reqBadAddr(reqBadAddr), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .intMask(intMask), .intTake(intTake), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .statusOut(statusOut), .causeOut(causeOut),
    .epcOut(epcOut), .badVaddrOut(badVaddrOut), .contextOut(contextOut),
    .entryHiOut(entryHiOut), .configOut(configOut), .pridOut(pridOut),
    .levelErr(levelErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic seed(input logic [31:0] st, input logic [31:0] ca, input logic [31:0] ep,
                      input logic [31:0] cx, input logic [31:0] hi);
    writeReg(3'd0, st); writeReg(3'd1, ca); writeReg(3'd2, ep);
    writeReg(3'd4, cx); writeReg(3'd5, hi);
    mStatus = st; mCause = ca; mEpc = ep; mCtx = cx; mHi = hi;
  endtask

  task automatic fire(input logic [17:0] code, input logic bd, input logic [31:0] pc,
                      input logic tlb, input logic [31:0] addr);
    logic erl, exl, rstCase, selBit;
    logic [9:0]  off;
    logic [31:0] expPc, fpc;
    logic [6:0]  mc;
    erl = mStatus[2]; exl = mStatus[1];
    rstCase = erl && (code[17:15] <= 3'd1);
    mc = {code[6:2], 2'b00};
    if (erl) begin
      case (code[17:15])
        3'd2: off = 10'h080;
        3'd3: off = 10'h100;
        default: off = 10'h000;
      endcase
      if (code[17:15] > 3'd3) mErr = 1'b1;
    end else if (mc >= 7'h08 && mc <= 7'h0C) off = 10'h000;
    else if (mc == 7'h00) off = 10'h200;
    else off = 10'h180;
    if (exl) off = 10'h180;
    selBit = erl ? mStatus[23] : mStatus[22];
    expPc = rstCase ? 32'hBFC00000 : ((selBit ? 32'hBFC00200 : 32'h80000000) + {22'd0, off});
    fpc = pc;
    if (tlb) begin
      mBad = addr;
      mCtx = (mCtx & 32'hFF80000F) | ((addr >> 9) & 32'h007FFFF0);
      mHi  = (addr & 32'hFFFFE000) | (mHi & 32'h00001FFF);
      fpc  = pc - 32'd4;
    end
    mCause = {mCause[31], 15'd0, code[15:0]};
    if (!exl && !rstCase) begin
      mStatus[1] = 1'b1;
      mEpc = bd ? fpc - 32'd4 : fpc;
      mCause[31] = bd;
    end
    @(negedge clk);
    reqValid = 1'b1; reqCode = code; reqBranchDelay = bd; reqTlbMiss = tlb;
    reqPc = pc; reqBadAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 redirectValid high", {31'd0, redirectValid}, 32'd1);
    check("R3/R4/R5/R7 redirectPc", redirectPc, expPc);
    check("R6/R4 status", statusOut, mStatus);
    check("R8/R6/R7 cause", causeOut, mCause);
    check("R6/R7/R9 epc", epcOut, mEpc);
    check("R4 levelErr", {31'd0, levelErr}, {31'd0, mErr});
    if (tlb) begin
      check("R9 badVaddr", badVaddrOut, mBad);
      check("R9 context", contextOut, mCtx);
      check("R9 entryHi", entryHiOut, mHi);
    end
    @(negedge clk);
    check("R2 redirectValid single", {31'd0, redirectValid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 redirectPc", redirectPc, 32'hBFC00000);
    check("R1 status", statusOut, 32'h70400004);
    check("R1 config", configOut, 32'h00000440);
    check("R1 prid", pridOut, 32'h00002E20);
    check("R1 redirectValid", {31'd0, redirectValid}, 32'd0);
    check("R1 levelErr", {31'd0, levelErr}, 32'd0);

    // R11: each select lands in its own register
    writeReg(3'd3, 32'h13572468);
    writeReg(3'd4, 32'h0F0F0F0F);
    writeReg(3'd5, 32'hA5A5A5A5);
    writeReg(3'd2, 32'h00400010);
    writeReg(3'd1, 32'h80000000);
    writeReg(3'd0, 32'h00010001);
    check("R11 badVaddr", badVaddrOut, 32'h13572468);
    check("R11 context", contextOut, 32'h0F0F0F0F);
    check("R11 entryHi", entryHiOut, 32'hA5A5A5A5);
    check("R11 epc", epcOut, 32'h00400010);
    check("R11 cause", causeOut, 32'h80000000);
    check("R11 status", statusOut, 32'h00010001);
    mBad = 32'h13572468;

    // R3 R5 R6 R7 R9: level-one sweep
    for (int exl = 0; exl < 2; exl++)
      for (int sel = 0; sel < 2; sel++)
        for (int bd = 0; bd < 2; bd++)
          for (int exc = 0; exc < 32; exc++) begin
            logic [31:0] st;
            logic tlb;
            st = 32'h00010001 | (32'(exl) << 1) | (32'(sel) << 22) | (32'(1 - sel) << 23);
            seed(st, {bd[0] ^ 1'b1, 31'h00005555}, 32'hDEAD0000 + 32'(exc),
                 32'h12345678 ^ 32'(exc), 32'h9ABCDEF0 + 32'(exc));
            tlb = (exc == 2 || exc == 3);
            fire(18'(exc << 2) | 18'(exc << 13), bd[0], 32'h00100000 + 32'(exc * 16),
                 tlb, 32'hC0DE0000 + 32'(exc * 32'h1234));
          end

    // R4 R5 R7: level-two sweep
    for (int exl = 0; exl < 2; exl++)
      for (int sel = 0; sel < 2; sel++)
        for (int bd = 0; bd < 2; bd++)
          for (int f = 0; f < 8; f++) begin
            logic [31:0] st;
            st = 32'h00000004 | (32'(exl) << 1) | (32'(sel) << 23) | (32'(1 - sel) << 22);
            seed(st, {bd[0] ^ 1'b1, 31'h00002222}, 32'hBEEF0000 + 32'(f),
                 32'h0, 32'h0);
            fire(18'(f << 15) | 18'h0024, bd[0], 32'h00200000 + 32'(f * 8), 1'b0, 32'h0);
          end

    // R10: interrupt qualification sweep
    for (int v = 0; v < 128; v++) begin
      logic [31:0] st, m;
      logic exp;
      st = (32'(v & 1)) | (32'((v >> 1) & 1) << 1) | (32'((v >> 2) & 1) << 2)
         | (32'((v >> 3) & 1) << 16) | (32'((v >> 4) & 1) << 10) | (32'((v >> 5) & 1) << 11);
      m = ((v >> 6) & 1) != 0 ? 32'h00000800 : 32'h00000400;
      writeReg(3'd0, st);
      intMask = m;
      @(negedge clk);
      exp = ((st & m) != 0) && st[0] && st[16] && !st[1] && !st[2];
      check("R10 intTake", {31'd0, intTake}, {31'd0, exp});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule